// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block gives a host processor access to eight 16-bit registers over an asynchronous parallel bus. A static mode input chooses the strobe style. With the mode input low, the host uses separate active-low read and write strobes. With it high, the host uses a single active-low data strobe and a direction line that is high for reads and low for writes. An active-low chip select gates every access in both modes. The bidirectional data bus appears as separate input, output and output-enable signals. A pad outside the block combines them.

Every host input passes through a two-flop synchronizer into the system clock domain, and strobe edges are found there. When a write strobe rises, the synchronized data and address are captured together into a holding stage. The holding register is written into the addressed register one system cycle later. A read places the addressed register on the output bus, and the output enable is high only while a valid read condition holds. The host must keep the mode input tied low unless it uses the combined-strobe style.

Top module: `hbif_regif`

## Requirements
- R1: After reset, all eight registers and the holding register are zero, and `data_oe` is low.
- R2: With `mode_sel`=0, a low-to-high edge of `wr_n_ds` while `cs_n` is low writes `data_in` to the register selected by `addr`.
- R3: With `mode_sel`=0, while `cs_n` and `rd_n_rw` are both low and `wr_n_ds` is high, `data_oe` is high and `data_out` holds the addressed register. The output is registered and rises on the third clock edge after the inputs change.
- R4: With `mode_sel`=1, a low-to-high edge of `wr_n_ds` (the data strobe) while `rd_n_rw` is low and `cs_n` is low writes `data_in` to the addressed register.
- R5: With `mode_sel`=1, while `rd_n_rw` is high and `wr_n_ds` and `cs_n` are low, `data_oe` is high and `data_out` holds the addressed register.
- R6: While `cs_n` is high, `data_oe` stays low and strobe edges write nothing, in either mode.
- R7: Read accesses never change register contents.
- R8: Data and address are captured together at the synchronized strobe edge. Input changes made one cycle after the strobe rises do not affect that write. The commit to the register lands one cycle after edge detection.
- R9: `data_oe` is low whenever no read condition is met, including while a write strobe is low. When `data_oe` is low, `data_out` is zero.
- R10: The 3-bit `addr` (bit 2 is the MSB) selects eight distinct locations, and a write to one location leaves the other seven unchanged.
- R11: With `mode_sel`=1, a data strobe rising edge while `rd_n_rw` is high writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0: separate read/write strobes; 1: data strobe plus direction line |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 3 | Register address, bit 2 MSB |
| wr_n_ds | input | 1 | Write strobe (mode 0) or data strobe (mode 1), active low |
| rd_n_rw | input | 1 | Read strobe (mode 0, active low) or direction, 1 = read (mode 1) |
| data_in | input | 16 | Data from the host bus, bit 15 MSB |
| data_out | output | 16 | Data driven to the host bus during reads |
| data_oe | output | 1 | Output enable for `data_out` |

## Verification
The assertions check, on every cycle, that the output is enabled only after a selected synchronized cycle and that read data matches the register addressed one cycle earlier. They also check that register contents change only on the cycle after a pending commit, and that the committed value equals the holding register. The holding register may change only on a detected write edge. The bench's scenarios cover the end-to-end protocol behaviour that only host stimulus can reveal: both strobe styles, the three-edge read latency, direction-line and chip-select gating of writes, address independence, and data changes right after the strobe edge.

// File: rtl/hbif_pkg.sv
package hbif_pkg;
  parameter int unsigned HB_DW = 16;
  parameter int unsigned HB_AW = 3;

  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_STROBE = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/hbif_sync.sv
module hbif_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/hbif_decode.sv
module hbif_decode
  import hbif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_s,
  input  logic cs_n_s,
  input  logic strb_s,
  input  logic dir_s,
  output logic wr_edge,
  output logic rd_cond
);
  logic strb_prev_q;
  logic rise;
  bus_mode_e mode;

  always_comb begin
    mode = bus_mode_e'(mode_s);
    rise = strb_s & ~strb_prev_q;
    if (mode == MODE_SPLIT) begin
      wr_edge = rise & ~cs_n_s;
      rd_cond = ~cs_n_s & ~dir_s & strb_s;
    end else begin
      wr_edge = rise & ~cs_n_s & ~dir_s;
      rd_cond = ~cs_n_s & dir_s & ~strb_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev_q <= 1'b1;
    else        strb_prev_q <= strb_s;
  end
endmodule

// File: rtl/hbif_regfile.sv
module hbif_regfile #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_edge,
  input  logic               rd_cond,
  input  logic [AW-1:0]      addr_s,
  input  logic [DW-1:0]      data_s,
  output logic [DW-1:0]      data_out,
  output logic               data_oe,
  output logic [DW-1:0]      hold_q,
  output logic               commit_q,
  output logic [AW-1:0]      tgt_q,
  output logic [(DW<<AW)-1:0] regs_flat
);
  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] hold_d;
  logic [AW-1:0] tgt_d;
  logic          hold_en;
  logic [DW-1:0] dout_d;
  logic [DW-1:0] dout_q;
  logic          oe_q;

  always_comb begin
    hold_en = wr_edge;
    hold_d  = hold_en ? data_s : hold_q;
    tgt_d   = hold_en ? addr_s : tgt_q;
    dout_d  = rd_cond ? regs_q[addr_s] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tgt_q    <= '0;
      commit_q <= 1'b0;
      dout_q   <= '0;
      oe_q     <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      tgt_q    <= tgt_d;
      commit_q <= hold_en;
      dout_q   <= dout_d;
      oe_q     <= rd_cond;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic entry_en;
    logic [DW-1:0] entry_d;

    always_comb begin
      entry_en = commit_q && (tgt_q == AW'(i));
      entry_d  = entry_en ? hold_q : regs_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= entry_d;
    end

    assign regs_flat[i*DW +: DW] = regs_q[i];
  end

  assign data_out = dout_q;
  assign data_oe  = oe_q;
endmodule

// File: rtl/hbif_regif.sv
module hbif_regif
  import hbif_pkg::*;
#(
  parameter int unsigned DW = HB_DW,
  parameter int unsigned AW = HB_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_n_ds,
  input  logic          rd_n_rw,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);
  localparam int unsigned SW = 4 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {AW{1'b0}}, {DW{1'b0}}};

  logic [1:0]     rst_pipe_q;
  logic           rst_sync_n;
  logic [SW-1:0]  raw_bus;
  logic [SW-1:0]  sync_bus;
  logic           mode_s;
  logic           cs_s;
  logic           strb_s;
  logic           dir_s;
  logic [AW-1:0]  addr_s;
  logic [DW-1:0]  data_s;
  logic           wr_edge;
  logic           rd_cond;
  logic [DW-1:0]  hold_q;
  logic           commit_q;
  logic [AW-1:0]  tgt_q;
  logic [(DW<<AW)-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw_bus = {mode_sel, cs_n, wr_n_ds, rd_n_rw, addr, data_in};

  hbif_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign {mode_s, cs_s, strb_s, dir_s, addr_s, data_s} = sync_bus;

  hbif_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_s  (mode_s),
    .cs_n_s  (cs_s),
    .strb_s  (strb_s),
    .dir_s   (dir_s),
    .wr_edge (wr_edge),
    .rd_cond (rd_cond)
  );

  hbif_regfile #(.DW(DW), .AW(AW)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_edge   (wr_edge),
    .rd_cond   (rd_cond),
    .addr_s    (addr_s),
    .data_s    (data_s),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .hold_q    (hold_q),
    .commit_q  (commit_q),
    .tgt_q     (tgt_q),
    .regs_flat (regs_flat)
  );
endmodule

// File: rtl/hbif_checker.sv
module hbif_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_s,
  input logic [AW-1:0]       addr_s,
  input logic                wr_edge,
  input logic                commit_q,
  input logic [AW-1:0]       tgt_q,
  input logic [DW-1:0]       hold_q,
  input logic [(DW<<AW)-1:0] regs_flat,
  input logic [DW-1:0]       data_out,
  input logic                data_oe
);
  logic [DW-1:0] rd_word;
  logic [DW-1:0] tgt_word;

  always_comb begin
    rd_word  = regs_flat[int'(addr_s)*DW +: DW];
    tgt_word = regs_flat[int'(tgt_q)*DW +: DW];
  end

  assert_oe_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(!cs_s));

  assert_read_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out == $past(rd_word)));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_q |=> $stable(regs_flat));

  assert_commit_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> (tgt_word == $past(hold_q)));

  assert_hold_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_edge |=> $stable(hold_q));

  assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> !wr_edge);
endmodule

bind hbif_regif hbif_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_s      (cs_s),
  .addr_s    (addr_s),
  .wr_edge   (wr_edge),
  .commit_q  (commit_q),
  .tgt_q     (tgt_q),
  .hold_q    (hold_q),
  .regs_flat (regs_flat),
  .data_out  (data_out),
  .data_oe   (data_oe)
);

// File: tb/hbif_regif_bench.sv
`timescale 1ns/1ps
module hbif_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_sel;
  logic        cs_n;
  logic [2:0]  addr;
  logic        wr_n_ds;
  logic        rd_n_rw;
  logic [15:0] data_in;
  logic [15:0] data_out;
  logic        data_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];

  always #4 clk = ~clk;

  hbif_regif u_hbif_regif (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .addr(addr),
    .wr_n_ds(wr_n_ds), .rd_n_rw(rd_n_rw), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_sel = m;
    cs_n = 1'b1; wr_n_ds = 1'b1; rd_n_rw = m ? 1'b0 : 1'b1;
    waitn(5);
  endtask

  task automatic wr_m0(input logic [2:0] a, input logic [15:0] d, input logic sel_n);
    @(negedge clk);
    addr = a; data_in = d; cs_n = sel_n;
    waitn(1); wr_n_ds = 1'b0;
    waitn(3);
    check(data_oe == 1'b0, "R9 oe during write", {15'd0, data_oe}, 16'd0);
    wr_n_ds = 1'b1;
    waitn(4); cs_n = 1'b1;
    waitn(4);
  endtask

  task automatic wr_m1(input logic [2:0] a, input logic [15:0] d, input logic dir, input logic sel_n);
    @(negedge clk);
    addr = a; data_in = d; rd_n_rw = dir; cs_n = sel_n;
    waitn(1); wr_n_ds = 1'b0;
    waitn(4); wr_n_ds = 1'b1;
    waitn(4); cs_n = 1'b1; rd_n_rw = 1'b0;
    waitn(4);
  endtask

  task automatic rd_m0(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n_rw = 1'b0;
    waitn(5);
    check(data_oe === 1'b1, req, {15'd0, data_oe}, 16'd1);
    check(data_out === exp, req, data_out, exp);
    rd_n_rw = 1'b1; cs_n = 1'b1;
    waitn(4);
    check(data_oe === 1'b0 && data_out === 16'd0, "R9 idle after read", data_out, 16'd0);
  endtask

  task automatic rd_m1(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n_rw = 1'b1;
    waitn(1); wr_n_ds = 1'b0;
    waitn(5);
    check(data_oe === 1'b1, req, {15'd0, data_oe}, 16'd1);
    check(data_out === exp, req, data_out, exp);
    wr_n_ds = 1'b1;
    waitn(4);
    check(data_oe === 1'b0, "R9 strobe released", {15'd0, data_oe}, 16'd0);
    cs_n = 1'b1; rd_n_rw = 1'b0;
    waitn(4);
  endtask

  task automatic t_reset_r1();
    check(data_oe === 1'b0, "R1 oe after reset", {15'd0, data_oe}, 16'd0);
    for (int i = 0; i < 8; i++) rd_m0(3'(i), 16'h0000, "R1 reg clear");
  endtask

  task automatic t_m0_rw_r2();
    for (int i = 0; i < 8; i++) begin
      model[i] = 16'h1111 * 16'(i + 1) ^ 16'h8000;
      wr_m0(3'(i), model[i], 1'b0);
    end
    for (int i = 7; i >= 0; i--) rd_m0(3'(i), model[i], "R2 R10 readback");
  endtask

  task automatic t_read_latency_r3();
    @(negedge clk);
    addr = 3'd4; cs_n = 1'b0; rd_n_rw = 1'b0;
    waitn(2);
    check(data_oe === 1'b0, "R3 oe not before third edge", {15'd0, data_oe}, 16'd0);
    waitn(1);
    check(data_oe === 1'b1 && data_out === model[4], "R3 oe at third edge", data_out, model[4]);
    rd_n_rw = 1'b1; cs_n = 1'b1;
    waitn(4);
  endtask

  task automatic t_rd_nochange_r7();
    for (int k = 0; k < 3; k++) rd_m0(3'd2, model[2], "R7 repeated reads");
    rd_m0(3'd3, model[3], "R7 neighbour after reads");
  endtask

  task automatic t_cs_high_r6();
    wr_m0(3'd1, 16'hDEAD, 1'b1);
    @(negedge clk);
    addr = 3'd1; cs_n = 1'b1; rd_n_rw = 1'b0;
    waitn(5);
    check(data_oe === 1'b0, "R6 no drive deselected", {15'd0, data_oe}, 16'd0);
    rd_n_rw = 1'b1;
    waitn(4);
    rd_m0(3'd1, model[1], "R6 write ignored deselected");
  endtask

  task automatic t_capture_r8();
    @(negedge clk);
    addr = 3'd6; data_in = 16'hA5C3; cs_n = 1'b0;
    waitn(1); wr_n_ds = 1'b0;
    waitn(3); wr_n_ds = 1'b1;
    waitn(1); addr = 3'd7; data_in = 16'h0F0F;
    waitn(5); cs_n = 1'b1;
    waitn(4);
    model[6] = 16'hA5C3;
    rd_m0(3'd6, model[6], "R8 captured at edge");
    rd_m0(3'd7, model[7], "R8 late change unused");
  endtask

  task automatic t_mode1();
    set_mode(1'b1);
    model[5] = 16'h5A5A;
    wr_m1(3'd5, model[5], 1'b0, 1'b0);
    rd_m1(3'd5, model[5], "R4 R5 strobe write/read");
    rd_m1(3'd0, model[0], "R5 other entry");
    wr_m1(3'd0, 16'hBEEF, 1'b1, 1'b0);
    rd_m1(3'd0, model[0], "R11 direction high no write");
    wr_m1(3'd5, 16'hCAFE, 1'b0, 1'b1);
    rd_m1(3'd5, model[5], "R6 mode1 deselected write");
    @(negedge clk);
    addr = 3'd5; rd_n_rw = 1'b1; cs_n = 1'b1; wr_n_ds = 1'b0;
    waitn(5);
    check(data_oe === 1'b0, "R6 mode1 no drive deselected", {15'd0, data_oe}, 16'd0);
    wr_n_ds = 1'b1; rd_n_rw = 1'b0;
    waitn(4);
    set_mode(1'b0);
    rd_m0(3'd5, model[5], "R10 mode back to split");
  endtask

  initial begin
    mode_sel = 1'b0; cs_n = 1'b1; addr = '0; wr_n_ds = 1'b1; rd_n_rw = 1'b1; data_in = '0;
    rst_n = 1'b0;
    waitn(4);
    rst_n = 1'b1;
    waitn(6);
    t_reset_r1();
    t_m0_rw_r2();
    t_read_latency_r3();
    t_rd_nochange_r7();
    t_cs_high_r6();
    t_capture_r8();
    t_mode1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule